// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Controller

This block runs one receive channel that fills host buffers listed in a circular ring of descriptors held in host memory. The host sets the ring base, the status writeback address and a configuration word through a small register port. It then advances a producer (write) index as it hands buffers over. The controller keeps its own consumer (read) index. For each buffer it fetches the descriptor through a request/acknowledge memory port and presents the buffer address and size to an external data mover. It then waits for that mover to report data beats and buffer completion.

When a buffer is closed, either by a completion pulse or by a quiet-time timeout, the controller writes the index of that descriptor to the status word in host memory. It then advances its read index and, if enabled, pulses the host interrupt. Filling stalls whenever the read index equals the write index. A two-bit run mode selects stop-now, stop-after-current-buffer or normal operation. An idle flag tells the host when a stopped channel has settled.

The control is a five-state machine. `S_IDLE` waits for run mode. `S_CHECK` compares the indices. `S_FETCH` reads the descriptor. `S_FILL` waits for the buffer to close. `S_WBACK` writes the status word. The transitions are:
- idle→check when the mode is run.
- check→idle when the mode is not run.
- check→fetch when a buffer is available.
- fetch→fill on acknowledge.
- fill→idle on stop-now.
- fill→wback on completion or timeout.
- wback→check on acknowledge.

Top module: `rxring_dma`

## Requirements
- R1: After reset the channel is idle: `chan_idle`=1, status register (offset 4) bit 24 = 1, `mem_req`=0, `irq`=0, `buf_valid`=0.
- R2: In run mode (config bits 31:30 = 10) with a free buffer, the controller issues a read (`mem_we`=0) at {ring_base[27:0],8'h00} + 4·read_index. On acknowledge, `buf_addr` = {mem_rdata[27:0],8'h00} with `buf_valid`=1; bits 31:28 of the descriptor are ignored.
- R3: A write to the write-index register (offset 2) is stored rounded down to a multiple of 8 and masked to the ring size; reading offset 2 returns the stored value.
- R4: When the read index equals the write index, no descriptor fetch is issued and the channel stays non-idle while in run mode.
- R5: A buffer closes on a `fill_done` pulse. The controller then writes (`mem_we`=1) to address {status_addr,4'h0} the word whose bits 11:0 hold the closed descriptor's index and whose bits 31:12 are 0. The read index then advances by one.
- R6: When config bits 13:12 = 01, `irq` pulses for exactly one cycle after each status writeback is acknowledged; with 00 it stays low.
- R7: With timeout T (config bits 11:4, nonzero), a buffer that has received at least one `fill_beat` is closed after T·TICK_CYCLES cycles without a new beat. A buffer with no beat is never closed by the timeout, and each beat restarts the count.
- R8: Mode 01 lets the buffer in progress finish and write back, then the channel goes idle without fetching another descriptor even if buffers are free.
- R9: Mode 00 (and reserved 11), including a config write of zero, abandons the buffer in progress without a writeback. The channel is idle within two cycles and the read index is unchanged.
- R10: The ring holds 2^L entries for L = config bits 23:20, clamped to 5..12. The read index wraps from 2^L−1 to 0, and the status register bits 11:0 report it.
- R11: `buf_kbytes` = 4·(B+1) for B = config bits 17:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 config, 1 ring base, 2 write index, 3 status address, 4 channel status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = status write, 0 = descriptor read |
| mem_addr | output | 36 | Byte address of the access |
| mem_wdata | output | 32 | Status word to write |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Descriptor word returned with acknowledge |
| fill_beat | input | 1 | Data arrived into the current buffer |
| fill_done | input | 1 | Current buffer is complete |
| buf_valid | output | 1 | A buffer is open for filling |
| buf_addr | output | 36 | Byte address of the open buffer |
| buf_kbytes | output | 5 | Size of each buffer in KiB |
| irq | output | 1 | Host interrupt pulse |
| chan_idle | output | 1 | Channel is stopped and idle |

## Verification
The bench builds the controller with TICK_CYCLES = 4, so a timeout value of 2 closes a buffer eight cycles after the last beat. Both the early-close window and the no-data case can then be observed in a few dozen cycles. The index width stays at its default of 12. The bench mostly runs a 32-entry ring, where a full lap of the read index, the stall at equal indices and the wrap to zero take only a few hundred cycles. It also programs ring-size codes 2 and 12 to exercise the clamp and the widest index mask.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_FETCH,
        S_FILL,
        S_WBACK
    } rx_state_t;

    localparam logic [1:0] MODE_STOP = 2'b00;
    localparam logic [1:0] MODE_EOF  = 2'b01;
    localparam logic [1:0] MODE_RUN  = 2'b10;

    localparam logic [2:0] RA_CFG   = 3'd0;
    localparam logic [2:0] RA_BASE  = 3'd1;
    localparam logic [2:0] RA_WIDX  = 3'd2;
    localparam logic [2:0] RA_STADR = 3'd3;
    localparam logic [2:0] RA_CHST  = 3'd4;

    localparam int ADDR_W = 36;
    localparam int DATA_W = 32;
endpackage

// File: rtl/rxring_regs.sv
module rxring_regs
    import rxring_pkg::*;
#(
    parameter int MIN_LOG2 = 5,
    parameter int MAX_LOG2 = 12,
    parameter int IDX_W    = MAX_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [IDX_W-1:0]  ridx,
    input  logic              idle,
    output logic [1:0]        mode,
    output logic [IDX_W-1:0]  idx_mask,
    output logic [IDX_W-1:0]  widx,
    output logic [27:0]       ring_base,
    output logic [31:0]       stat_addr,
    output logic              irq_en,
    output logic [7:0]        tmo_limit,
    output logic [4:0]        buf_kbytes
);
    logic [31:0]      cfg_q;
    logic [27:0]      base_q;
    logic [31:0]      stat_q;
    logic [IDX_W-1:0] widx_q;
    logic [3:0]       lg_raw;
    logic [3:0]       lg_eff;
    logic [IDX_W-1:0] low_clear;

    always_comb begin
        lg_raw = cfg_q[23:20];
        if (int'(lg_raw) < MIN_LOG2)
            lg_eff = 4'(MIN_LOG2);
        else if (int'(lg_raw) > MAX_LOG2)
            lg_eff = 4'(MAX_LOG2);
        else
            lg_eff = lg_raw;
        idx_mask  = IDX_W'((33'd1 << lg_eff) - 33'd1);
        low_clear = ~IDX_W'(7);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            base_q <= '0;
            stat_q <= '0;
            widx_q <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                RA_CFG:   cfg_q  <= reg_wdata;
                RA_BASE:  base_q <= reg_wdata[27:0];
                RA_WIDX:  widx_q <= reg_wdata[IDX_W-1:0] & low_clear & idx_mask;
                RA_STADR: stat_q <= reg_wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CFG:   reg_rdata = cfg_q;
            RA_BASE:  reg_rdata = {4'h0, base_q};
            RA_WIDX:  reg_rdata = 32'(widx);
            RA_STADR: reg_rdata = stat_q;
            RA_CHST: begin
                reg_rdata     = 32'(ridx);
                reg_rdata[24] = idle;
            end
            default:  reg_rdata = '0;
        endcase
    end

    assign mode       = cfg_q[31:30];
    assign widx       = widx_q & idx_mask;
    assign ring_base  = base_q;
    assign stat_addr  = stat_q;
    assign irq_en     = (cfg_q[13:12] == 2'b01);
    assign tmo_limit  = cfg_q[11:4];
    assign buf_kbytes = 5'(({3'b000, cfg_q[17:16]} + 5'd1) << 2);

    // R3
    widx_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_WIDX) |=> (widx_q[2:0] == 3'b000));
endmodule

// File: rtl/rxring_tmo.sv
module rxring_tmo #(
    parameter int TICK_CYCLES = 4000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       armed,
    input  logic       beat,
    input  logic [7:0] limit,
    output logic       expire
);
    localparam int PRE_W = $clog2(TICK_CYCLES + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

    logic [PRE_W-1:0] pre_q;
    logic [7:0]       units_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !armed || beat) begin
            pre_q   <= '0;
            units_q <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
            if (units_q != limit)
                units_q <= units_q + 8'd1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign expire = armed && (limit != 8'd0) && (units_q == limit);

    // R7
    units_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !beat && $stable(limit) && units_q != limit) |=> (units_q <= limit));
endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
    import rxring_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [IDX_W-1:0]  idx_mask,
    input  logic [IDX_W-1:0]  widx,
    input  logic [27:0]       ring_base,
    input  logic [31:0]       stat_addr,
    input  logic              irq_en,
    input  logic              mem_ack,
    input  logic [27:0]       desc_word,
    input  logic              fill_beat,
    input  logic              fill_done,
    input  logic              expire,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              buf_valid,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              irq,
    output logic              idle,
    output logic              armed,
    output logic [IDX_W-1:0]  ridx
);
    rx_state_t        state_q, state_d;
    logic [IDX_W-1:0] ridx_q;
    logic [ADDR_W-1:0] bufa_q;
    logic             has_data_q;
    logic             irq_q;
    logic             abort;
    logic             can_fill;

    assign abort    = (mode != MODE_RUN) && (mode != MODE_EOF);
    assign can_fill = (ridx_q != widx);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (mode == MODE_RUN) state_d = S_CHECK;
            S_CHECK: begin
                if (mode != MODE_RUN) state_d = S_IDLE;
                else if (can_fill)    state_d = S_FETCH;
            end
            S_FETCH: if (mem_ack) state_d = S_FILL;
            S_FILL: begin
                if (abort)                       state_d = S_IDLE;
                else if (fill_done || expire)    state_d = S_WBACK;
            end
            S_WBACK: if (mem_ack) state_d = S_CHECK;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = {ring_base, 8'h00} + ADDR_W'({ridx_q, 2'b00});
            end
            S_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {stat_addr, 4'h0};
                mem_wdata = DATA_W'(ridx_q);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ridx_q     <= '0;
            bufa_q     <= '0;
            has_data_q <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            irq_q <= (state_q == S_WBACK) && mem_ack && irq_en;
            if (state_q == S_FETCH && mem_ack)
                bufa_q <= {desc_word, 8'h00};
            if (state_q != S_FILL)
                has_data_q <= 1'b0;
            else if (fill_beat)
                has_data_q <= 1'b1;
            if (state_q == S_WBACK && mem_ack)
                ridx_q <= (ridx_q + 1'b1) & idx_mask;
        end
    end

    assign buf_valid = (state_q == S_FILL);
    assign buf_addr  = bufa_q;
    assign irq       = irq_q;
    assign idle      = (state_q == S_IDLE);
    assign armed     = (state_q == S_FILL) && has_data_q;
    assign ridx      = ridx_q;

    // R4
    empty_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK && ridx_q == widx) |=> (state_q != S_FETCH));
    // R6
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && $stable(ring_base) && $stable(stat_addr))
            |=> (mem_req && $stable(mem_addr)));
    // R10
    ridx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WBACK && mem_ack) |=>
            (ridx_q == (($past(ridx_q) + 1'b1) & $past(idx_mask))));
    // R9
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL && abort) |=> (idle && $stable(ridx_q)));
endmodule

// File: rtl/rxring_dma.sv
module rxring_dma
    import rxring_pkg::*;
#(
    parameter int TICK_CYCLES = 4000,
    parameter int MIN_LOG2    = 5,
    parameter int MAX_LOG2    = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [35:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    input  logic        fill_beat,
    input  logic        fill_done,
    output logic        buf_valid,
    output logic [35:0] buf_addr,
    output logic [4:0]  buf_kbytes,
    output logic        irq,
    output logic        chan_idle
);
    localparam int IDX_W = MAX_LOG2;

    logic [1:0]       mode;
    logic [IDX_W-1:0] idx_mask;
    logic [IDX_W-1:0] widx;
    logic [IDX_W-1:0] ridx;
    logic [27:0]      ring_base;
    logic [31:0]      stat_addr;
    logic             irq_en;
    logic [7:0]       tmo_limit;
    logic             expire;
    logic             armed;
    logic             idle;

    rxring_regs #(
        .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ridx(ridx), .idle(idle),
        .mode(mode), .idx_mask(idx_mask), .widx(widx), .ring_base(ring_base),
        .stat_addr(stat_addr), .irq_en(irq_en), .tmo_limit(tmo_limit),
        .buf_kbytes(buf_kbytes)
    );

    rxring_tmo #(.TICK_CYCLES(TICK_CYCLES)) u_tmo (
        .clk(clk), .rst_n(rst_n), .armed(armed), .beat(fill_beat),
        .limit(tmo_limit), .expire(expire)
    );

    rxring_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode), .idx_mask(idx_mask), .widx(widx),
        .ring_base(ring_base), .stat_addr(stat_addr), .irq_en(irq_en),
        .mem_ack(mem_ack), .desc_word(mem_rdata[27:0]), .fill_beat(fill_beat),
        .fill_done(fill_done), .expire(expire), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .buf_valid(buf_valid),
        .buf_addr(buf_addr), .irq(irq), .idle(idle), .armed(armed), .ridx(ridx)
    );

    assign chan_idle = idle;
endmodule

// File: tb/test_rxring_dma.sv
module test_rxring_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        fill_beat = 1'b0;
    logic        fill_done = 1'b0;
    logic        buf_valid;
    logic [35:0] buf_addr;
    logic [4:0]  buf_kbytes;
    logic        irq, chan_idle;

    int n_chk = 0, n_bad = 0;
    int req_cnt = 0, wr_cnt = 0, irq_cnt = 0;
    logic [35:0] last_addr = '0;
    logic        last_we = 1'b0;
    logic [31:0] last_wdata = '0;
    bit          finished = 1'b0;

    localparam logic [27:0] BASE = 28'h0012340;
    localparam logic [31:0] STAD = 32'h00ABCDE;

    always #4 clk = ~clk;

    rxring_dma #(.TICK_CYCLES(4)) i_rxring_dma (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .fill_beat(fill_beat),
        .fill_done(fill_done), .buf_valid(buf_valid), .buf_addr(buf_addr),
        .buf_kbytes(buf_kbytes), .irq(irq), .chan_idle(chan_idle)
    );

    // memory responder and event counters
    initial begin
        forever begin
            @(negedge clk);
            if (irq) irq_cnt++;
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                mem_ack    = 1'b1;
                req_cnt++;
                last_addr  = mem_addr;
                last_we    = mem_we;
                last_wdata = mem_wdata;
                if (mem_we) wr_cnt++;
                mem_rdata  = {4'hF, 12'h5A3, mem_addr[15:0]};
            end
        end
    end

    function automatic logic [31:0] mk_cfg(input logic [1:0] md, input logic [3:0] lg,
                                           input logic [1:0] bs, input logic [1:0] dst,
                                           input logic [7:0] tmo);
        return {md, 2'b00, 4'h0, lg, 2'b00, bs, 2'b00, dst, tmo, 4'h0};
    endfunction

    function automatic logic [35:0] fetch_addr(input int r);
        return {BASE, 8'h00} + 36'(r * 4);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_valid(input string tag);
        for (int i = 0; i < 100 && !buf_valid; i++) @(negedge clk);
        check({tag, " buffer opened"}, 64'(buf_valid), 64'd1);
    endtask

    task automatic fill_one(input string tag, input int exp_idx);
        int w0;
        wait_valid(tag);
        w0 = wr_cnt;
        @(negedge clk); fill_beat = 1'b1;
        @(negedge clk); fill_beat = 1'b0; fill_done = 1'b1;
        @(negedge clk); fill_done = 1'b0;
        for (int i = 0; i < 50 && wr_cnt == w0; i++) @(negedge clk);
        check({tag, " writeback index"}, 64'(last_wdata), 64'(exp_idx));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 idle", 64'(chan_idle), 64'd1);
        check("R1 req", 64'(mem_req), 64'd0);
        check("R1 irq/valid", 64'({irq, buf_valid}), 64'd0);
        rd_reg(3'd4, d);
        check("R1 status bit24", 64'(d[24]), 64'd1);
    endtask

    task automatic t_widx();
        logic [31:0] d;
        wr_reg(3'd0, mk_cfg(2'b00, 4'd5, 2'b00, 2'b00, 8'd0));
        wr_reg(3'd2, 32'd13); rd_reg(3'd2, d);
        check("R3 round down", 64'(d), 64'd8);
        wr_reg(3'd2, 32'd45); rd_reg(3'd2, d);
        check("R3 mask to ring", 64'(d), 64'd8);
        wr_reg(3'd0, mk_cfg(2'b00, 4'd2, 2'b00, 2'b00, 8'd0));
        wr_reg(3'd2, 32'd40); rd_reg(3'd2, d);
        check("R10 size clamp to 32", 64'(d), 64'd8);
        wr_reg(3'd0, mk_cfg(2'b00, 4'd12, 2'b00, 2'b00, 8'd0));
        wr_reg(3'd2, 32'hFFF); rd_reg(3'd2, d);
        check("R3 4096 ring", 64'(d), 64'hFF8);
        wr_reg(3'd0, mk_cfg(2'b00, 4'd5, 2'b00, 2'b00, 8'd0));
        wr_reg(3'd2, 32'd0);
    endtask

    task automatic t_stall();
        int r0;
        wr_reg(3'd1, {4'h0, BASE});
        wr_reg(3'd3, STAD);
        wr_reg(3'd0, mk_cfg(2'b10, 4'd5, 2'b01, 2'b01, 8'd2));
        r0 = req_cnt;
        cycles(10);
        check("R4 no fetch on empty ring", 64'(req_cnt - r0), 64'd0);
        check("R4 not idle while running", 64'(chan_idle), 64'd0);
    endtask

    task automatic t_first_fill();
        int i0, r0;
        logic [31:0] d;
        i0 = irq_cnt;
        wr_reg(3'd2, 32'd8);
        wait_valid("R2");
        check("R2 fetch addr", 64'(last_addr), 64'(fetch_addr(0)));
        check("R2 fetch is read", 64'(last_we), 64'd0);
        check("R2 buf addr", 64'(buf_addr), 64'({12'h5A3, fetch_addr(0)[15:0], 8'h00}));
        check("R11 buf size 8K", 64'(buf_kbytes), 64'd8);
        fill_one("R5", 0);
        check("R5 status addr", 64'(last_addr), 64'({STAD, 4'h0}));
        check("R5 status write", 64'(last_we), 64'd1);
        cycles(3);
        check("R6 one irq", 64'(irq_cnt - i0), 64'd1);
        wait_valid("R2 next");
        check("R2 second fetch addr", 64'(last_addr), 64'(fetch_addr(1)));
        for (int k = 1; k < 8; k++) fill_one("R5 run", k);
        r0 = req_cnt;
        cycles(10);
        check("R4 stall at full", 64'(req_cnt - r0), 64'd0);
        rd_reg(3'd4, d);
        check("R10 status ridx", 64'(d[11:0]), 64'd8);
    endtask

    task automatic t_noirq();
        int i0;
        wr_reg(3'd0, mk_cfg(2'b10, 4'd5, 2'b01, 2'b00, 8'd2));
        i0 = irq_cnt;
        wr_reg(3'd2, 32'd16);
        fill_one("R6 dest none", 8);
        cycles(3);
        check("R6 no irq", 64'(irq_cnt - i0), 64'd0);
    endtask

    task automatic t_timeout();
        int w0;
        wr_reg(3'd0, mk_cfg(2'b10, 4'd5, 2'b01, 2'b01, 8'd2));
        wait_valid("R7");
        w0 = wr_cnt;
        cycles(40);
        check("R7 no close without data", 64'(wr_cnt - w0), 64'd0);
        @(negedge clk); fill_beat = 1'b1;
        @(negedge clk); fill_beat = 1'b0;
        cycles(3);
        check("R7 not early", 64'(wr_cnt - w0), 64'd0);
        @(negedge clk); fill_beat = 1'b1;
        @(negedge clk); fill_beat = 1'b0;
        cycles(5);
        check("R7 beat restarts count", 64'(wr_cnt - w0), 64'd0);
        for (int i = 0; i < 30 && wr_cnt == w0; i++) @(negedge clk);
        check("R7 closed by timeout", 64'(wr_cnt - w0), 64'd1);
        check("R7 timeout index", 64'(last_wdata), 64'd9);
    endtask

    task automatic t_pause_eof();
        int r0;
        wait_valid("R8");
        wr_reg(3'd0, mk_cfg(2'b01, 4'd5, 2'b01, 2'b01, 8'd2));
        cycles(2);
        check("R8 buffer kept open", 64'(buf_valid), 64'd1);
        r0 = req_cnt;
        fill_one("R8 finishing", 10);
        cycles(10);
        check("R8 idle after frame", 64'(chan_idle), 64'd1);
        check("R8 no further fetch", 64'(req_cnt - r0), 64'd1);
    endtask

    task automatic t_stop();
        int w0;
        logic [31:0] d;
        wr_reg(3'd0, mk_cfg(2'b10, 4'd5, 2'b01, 2'b01, 8'd2));
        wait_valid("R9");
        w0 = wr_cnt;
        wr_reg(3'd0, 32'd0);
        cycles(1);
        check("R9 idle", 64'(chan_idle), 64'd1);
        check("R9 buffer dropped", 64'(buf_valid), 64'd0);
        cycles(10);
        check("R9 no writeback", 64'(wr_cnt - w0), 64'd0);
        rd_reg(3'd4, d);
        check("R9 status", 64'({d[24], d[11:0]}), 64'({1'b1, 12'd11}));
    endtask

    task automatic t_wrap();
        int r0;
        logic [31:0] d;
        wr_reg(3'd0, mk_cfg(2'b10, 4'd5, 2'b11, 2'b01, 8'd2));
        check("R11 buf size 16K", 64'(buf_kbytes), 64'd16);
        for (int k = 11; k < 16; k++) fill_one("R10 lap", k);
        wr_reg(3'd2, 32'd0);
        for (int k = 16; k < 32; k++) fill_one("R10 lap", k);
        r0 = req_cnt;
        cycles(10);
        rd_reg(3'd4, d);
        check("R10 wrapped ridx", 64'(d[11:0]), 64'd0);
        check("R10 stall after wrap", 64'(req_cnt - r0), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_widx();
        t_stall();
        t_first_fill();
        t_noirq();
        t_timeout();
        t_pause_eof();
        t_stop();
        t_wrap();
        finish_run();
    end
endmodule